// File: doc/BRIEF.md
# Flash Autoselect Command Sequencer

This block sits on the command side of a parallel flash bus. It watches every write cycle for a three-step entry sequence: two unlock writes, then a bank-addressed identify command. When that sequence completes, the block enters an identify mode. In that mode, reads that fall in the selected bank return identification words and per-block write-protect status instead of array contents. A reset command leaves the mode, and it also abandons a partly entered sequence.

Writes carry a word address and an 8-bit command byte. Reads carry a word address together with the array word that the memory core returns for that address in the same cycle. The block registers the read result and presents it one cycle later, with a valid flag. The address splits into fields as follows:

- The top `BANK_W` bits are the bank.
- The top `BLK_W` bits are the block index into the protect vector.
- The remaining low bits below the block field are the identify offset.

The block has four named states. `ST_IDLE` is the normal read state. `ST_UNLK1` means the first unlock write has been seen. `ST_UNLK2` means the second unlock write has been seen. `ST_ASEL` is identify mode. The transitions are:

- `ST_IDLE` to `ST_UNLK1` on AAh written to 555h.
- `ST_UNLK1` to `ST_UNLK2` on 55h written to 2AAh.
- `ST_UNLK2` to `ST_ASEL` on 90h written to 555h, with the bank bits captured.
- Any other write in `ST_UNLK1` or `ST_UNLK2` goes to `ST_IDLE`.
- In `ST_ASEL`, an F0h write goes to `ST_IDLE`. Every other write keeps the state.

Top module: `flash_asel_top`

## Requirements
- R1: After reset the block is in `ST_IDLE`, `asel_active` is 0 and `rd_valid` is 0.
- R2: The three writes must come in order: AAh to an address whose non-bank bits equal 555h, then 55h to non-bank bits 2AAh, then 90h to non-bank bits 555h. After that sequence, `asel_active` is 1 from the clock edge that takes the third write. The bank bits of the third write select the identify bank.
- R3: A write with the wrong command byte or the wrong address in `ST_UNLK1` or `ST_UNLK2` returns to `ST_IDLE`. A later 90h write then does not enter identify mode, and a fresh full sequence is needed.
- R4: An F0h write in `ST_ASEL` clears `asel_active` at that clock edge. An F0h write in `ST_UNLK1` or `ST_UNLK2` returns to `ST_IDLE`.
- R5: When identify mode is off, a read returns `array_rdata` on `rd_data` one cycle after `rd_en`. `rd_valid` is high in exactly the cycle after each `rd_en`.
- R6: In identify mode, a read in the identify bank at offset 0 returns parameter `MFR_CODE`, and a read at offset 1 returns parameter `DEV_CODE`.
- R7: In identify mode, a read in the identify bank whose address bits 6, 1 and 0 are 0, 1 and 0 returns the protect bit of the addressed block (`protect_vec[rd_addr[ADDR_W-1 -: BLK_W]]`) on bit 0. All other bits are 0.
- R8: In identify mode, a read outside the identify bank returns `array_rdata`.
- R9: In identify mode, a read in the identify bank at any other offset returns 0.
- R10: In `ST_ASEL`, writes other than F0h are ignored: `asel_active` stays 1 and identify reads are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_cmd | input | 8 | Command byte of the write |
| rd_en | input | 1 | Bus read strobe |
| rd_addr | input | ADDR_W | Word address of the read |
| array_rdata | input | DATA_W | Array word for `rd_addr`, same cycle as `rd_en` |
| protect_vec | input | 2**BLK_W | Write-protect status, one bit per block |
| rd_data | output | DATA_W | Registered read result |
| rd_valid | output | 1 | `rd_data` is valid this cycle |
| asel_active | output | 1 | Identify mode is on |

## Verification
A write changes state at the clock edge that samples it, so `asel_active` is due one cycle after the write is driven. The bench drives every input at a falling edge and samples at the next falling edge. A read result passes through one register, so `rd_data` and `rd_valid` are also due one cycle after `rd_en`. The read task samples them at the falling edge that follows the one where the read was driven. Each task therefore checks an output half a cycle after the rising edge that should have produced it, and never at an edge.

// File: rtl/flash_asel_pkg.sv
package flash_asel_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_UNLK1 = 2'd1,
        ST_UNLK2 = 2'd2,
        ST_ASEL  = 2'd3
    } asel_state_e;

    localparam logic [7:0] CMD_UNLK_A = 8'hAA;
    localparam logic [7:0] CMD_UNLK_B = 8'h55;
    localparam logic [7:0] CMD_IDENT  = 8'h90;
    localparam logic [7:0] CMD_RESET  = 8'hF0;

    localparam int UNLK_ADDR_A = 'h555;
    localparam int UNLK_ADDR_B = 'h2AA;

endpackage

// File: rtl/flash_asel_seq.sv
module flash_asel_seq
    import flash_asel_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_cmd,
    output asel_state_e       state_q,
    output logic [BANK_W-1:0] bank_q
);

    localparam int LOW_W = ADDR_W - BANK_W;
    localparam logic [LOW_W-1:0] ADDR_A = LOW_W'(UNLK_ADDR_A);
    localparam logic [LOW_W-1:0] ADDR_B = LOW_W'(UNLK_ADDR_B);

    asel_state_e state_d;
    logic [BANK_W-1:0] bank_d;
    logic [LOW_W-1:0]  low_addr;
    logic hit_a, hit_b, hit_id;

    assign low_addr = wr_addr[LOW_W-1:0];
    assign hit_a    = (low_addr == ADDR_A) && (wr_cmd == CMD_UNLK_A);
    assign hit_b    = (low_addr == ADDR_B) && (wr_cmd == CMD_UNLK_B);
    assign hit_id   = (low_addr == ADDR_A) && (wr_cmd == CMD_IDENT);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            bank_q  <= '0;
        end else begin
            state_q <= state_d;
            bank_q  <= bank_d;
        end
    end

    // next state and bank capture
    always_comb begin
        state_d = state_q;
        bank_d  = bank_q;
        if (wr_en) begin
            unique case (state_q)
                ST_IDLE:  state_d = hit_a ? ST_UNLK1 : ST_IDLE;
                ST_UNLK1: state_d = hit_b ? ST_UNLK2 : ST_IDLE;
                ST_UNLK2: begin
                    if (hit_id) begin
                        state_d = ST_ASEL;
                        bank_d  = wr_addr[ADDR_W-1 -: BANK_W];
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
                ST_ASEL:  state_d = (wr_cmd == CMD_RESET) ? ST_IDLE : ST_ASEL;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/flash_asel_rdmux.sv
module flash_asel_rdmux #(
    parameter int                ADDR_W   = 16,
    parameter int                DATA_W   = 16,
    parameter int                BANK_W   = 2,
    parameter int                BLK_W    = 4,
    parameter logic [DATA_W-1:0] MFR_CODE = 16'h00EC,
    parameter logic [DATA_W-1:0] DEV_CODE = 16'h22A5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rd_en,
    input  logic [ADDR_W-1:0]    rd_addr,
    input  logic [DATA_W-1:0]    array_rdata,
    input  logic [(1<<BLK_W)-1:0] protect_vec,
    input  logic                 asel_on,
    input  logic [BANK_W-1:0]    bank_sel,
    output logic [DATA_W-1:0]    rd_data,
    output logic                 rd_valid
);

    localparam int OFS_W = ADDR_W - BLK_W;

    logic [OFS_W-1:0]  offset;
    logic [BLK_W-1:0]  blk_idx;
    logic              in_bank;
    logic              prot_pat;
    logic [DATA_W-1:0] word_d;

    assign offset   = rd_addr[OFS_W-1:0];
    assign blk_idx  = rd_addr[ADDR_W-1 -: BLK_W];
    assign in_bank  = (rd_addr[ADDR_W-1 -: BANK_W] == bank_sel);
    assign prot_pat = !offset[6] && offset[1] && !offset[0];

    always_comb begin
        word_d = array_rdata;
        if (asel_on && in_bank) begin
            if (offset == OFS_W'(0))
                word_d = MFR_CODE;
            else if (offset == OFS_W'(1))
                word_d = DEV_CODE;
            else if (prot_pat)
                word_d = {{(DATA_W-1){1'b0}}, protect_vec[blk_idx]};
            else
                word_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en)
                rd_data <= word_d;
        end
    end

endmodule

// File: rtl/flash_asel_top.sv
module flash_asel_top
    import flash_asel_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter int                DATA_W   = 16,
    parameter int                BANK_W   = 2,
    parameter int                BLK_W    = 4,
    parameter logic [DATA_W-1:0] MFR_CODE = 16'h00EC,
    parameter logic [DATA_W-1:0] DEV_CODE = 16'h22A5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [7:0]            wr_cmd,
    input  logic                  rd_en,
    input  logic [ADDR_W-1:0]     rd_addr,
    input  logic [DATA_W-1:0]     array_rdata,
    input  logic [(1<<BLK_W)-1:0] protect_vec,
    output logic [DATA_W-1:0]     rd_data,
    output logic                  rd_valid,
    output logic                  asel_active
);

    asel_state_e       state_q;
    logic [BANK_W-1:0] bank_q;

    flash_asel_seq #(
        .ADDR_W (ADDR_W),
        .BANK_W (BANK_W)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_cmd  (wr_cmd),
        .state_q (state_q),
        .bank_q  (bank_q)
    );

    assign asel_active = (state_q == ST_ASEL);

    flash_asel_rdmux #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .BANK_W   (BANK_W),
        .BLK_W    (BLK_W),
        .MFR_CODE (MFR_CODE),
        .DEV_CODE (DEV_CODE)
    ) u_rdmux (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_en       (rd_en),
        .rd_addr     (rd_addr),
        .array_rdata (array_rdata),
        .protect_vec (protect_vec),
        .asel_on     (asel_active),
        .bank_sel    (bank_q),
        .rd_data     (rd_data),
        .rd_valid    (rd_valid)
    );

endmodule

// File: rtl/flash_asel_chk.sv
module flash_asel_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [7:0]        wr_cmd,
    input logic              rd_en,
    input logic [DATA_W-1:0] array_rdata,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_valid,
    input logic              asel_active
);

    // R2: identify mode only ever starts on a 90h write
    p_entry_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(asel_active) |-> $past(wr_en && (wr_cmd == 8'h90)));

    // R4: reset command leaves identify mode
    p_reset_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (asel_active && wr_en && (wr_cmd == 8'hF0)) |=> !asel_active);

    // R10: other writes keep identify mode
    p_mode_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (asel_active && !(wr_en && (wr_cmd == 8'hF0))) |=> asel_active);

    // R5: valid follows each read by one cycle
    p_valid_timing_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    p_valid_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);

    // R5: normal mode passes array data through
    p_array_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !asel_active) |=> (rd_data == $past(array_rdata)));

endmodule

bind flash_asel_top flash_asel_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_cmd      (wr_cmd),
    .rd_en       (rd_en),
    .array_rdata (array_rdata),
    .rd_data     (rd_data),
    .rd_valid    (rd_valid),
    .asel_active (asel_active)
);

// File: tb/flash_asel_top_tb_top.sv
`timescale 1ns/1ps
module flash_asel_top_tb_top;

    localparam int          ADDR_W = 16;
    localparam int          DATA_W = 16;
    localparam logic [15:0] MFR    = 16'h00EC;
    localparam logic [15:0] DEV    = 16'h22A5;
    localparam logic [15:0] PVEC   = 16'hA5C3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [7:0]        wr_cmd = '0;
    logic              rd_en = 1'b0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [DATA_W-1:0] array_rdata = '0;
    logic [15:0]       protect_vec = PVEC;
    logic [DATA_W-1:0] rd_data;
    logic              rd_valid;
    logic              asel_active;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    flash_asel_top #(.MFR_CODE(MFR), .DEV_CODE(DEV)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_cmd(wr_cmd), .rd_en(rd_en), .rd_addr(rd_addr),
        .array_rdata(array_rdata), .protect_vec(protect_vec),
        .rd_data(rd_data), .rd_valid(rd_valid), .asel_active(asel_active)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(logic [15:0] a, logic [7:0] c);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_cmd = c;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(logic [15:0] a, logic [15:0] arr, output logic [15:0] d);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a; array_rdata = arr;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
        check("R5 rd_valid", 32'(rd_valid), 32'd1);
    endtask

    task automatic enter(logic [1:0] bank);
        do_write(16'h0555, 8'hAA);
        do_write(16'h02AA, 8'h55);
        do_write({bank, 14'h0555}, 8'h90);
    endtask

    task automatic t_reset();
        check("R1 asel_active", 32'(asel_active), 32'd0);
        check("R1 rd_valid", 32'(rd_valid), 32'd0);
    endtask

    task automatic t_normal_read();
        logic [15:0] d;
        do_read(16'h4000, 16'h1234, d);
        check("R5 array data", 32'(d), 32'h1234);
        @(negedge clk);
        check("R5 valid drops", 32'(rd_valid), 32'd0);
    endtask

    task automatic t_entry_and_ids();
        logic [15:0] d;
        do_write(16'h0555, 8'hAA);
        check("R2 not yet", 32'(asel_active), 32'd0);
        do_write(16'h02AA, 8'h55);
        do_write(16'h4555, 8'h90);
        check("R2 entered", 32'(asel_active), 32'd1);
        do_read(16'h4000, 16'h1111, d);
        check("R6 mfr", 32'(d), 32'(MFR));
        do_read(16'h4001, 16'h1111, d);
        check("R6 dev", 32'(d), 32'(DEV));
    endtask

    task automatic t_protect();
        logic [15:0] d;
        do_read(16'h5002, 16'hFFFF, d);
        check("R7 blk5", 32'(d), 32'd0);
        do_read(16'h6002, 16'hFFFF, d);
        check("R7 blk6", 32'(d), 32'd1);
        do_read(16'h7F02, 16'hFFFF, d);
        check("R7 blk7", 32'(d), 32'd1);
        do_read(16'h4002, 16'hFFFF, d);
        check("R7 blk4", 32'(d), 32'd0);
    endtask

    task automatic t_other_bank_and_offsets();
        logic [15:0] d;
        do_read(16'h8002, 16'h5A5A, d);
        check("R8 other bank", 32'(d), 32'h5A5A);
        do_read(16'h0000, 16'hBEEF, d);
        check("R8 bank0", 32'(d), 32'hBEEF);
        do_read(16'h7042, 16'hFFFF, d);
        check("R9 A6 set", 32'(d), 32'd0);
        do_read(16'h4005, 16'hFFFF, d);
        check("R9 ofs5", 32'(d), 32'd0);
    endtask

    task automatic t_ignored_writes();
        logic [15:0] d;
        do_write(16'h0555, 8'hAA);
        do_write(16'h4555, 8'h90);
        do_write(16'h0555, 8'hF1);
        check("R10 still active", 32'(asel_active), 32'd1);
        do_read(16'h4001, 16'h0000, d);
        check("R10 ids intact", 32'(d), 32'(DEV));
    endtask

    task automatic t_exit();
        logic [15:0] d;
        do_write(16'h1234, 8'hF0);
        check("R4 exit", 32'(asel_active), 32'd0);
        do_read(16'h4000, 16'h7777, d);
        check("R4 array after exit", 32'(d), 32'h7777);
    endtask

    task automatic t_broken();
        do_write(16'h0555, 8'hAA);
        do_write(16'h02AA, 8'h56);
        do_write(16'h0555, 8'h90);
        check("R3 bad data", 32'(asel_active), 32'd0);
        do_write(16'h0555, 8'hAA);
        do_write(16'h02AB, 8'h55);
        do_write(16'h0555, 8'h90);
        check("R3 bad addr", 32'(asel_active), 32'd0);
        do_write(16'h0555, 8'hAA);
        do_write(16'h02AA, 8'h55);
        do_write(16'h0556, 8'h90);
        do_write(16'h0555, 8'h90);
        check("R3 bad third", 32'(asel_active), 32'd0);
    endtask

    task automatic t_partial_reset();
        do_write(16'h0555, 8'hAA);
        do_write(16'h0000, 8'hF0);
        do_write(16'h02AA, 8'h55);
        do_write(16'h0555, 8'h90);
        check("R4 F0 in unlock1", 32'(asel_active), 32'd0);
        do_write(16'h0555, 8'hAA);
        do_write(16'h02AA, 8'h55);
        do_write(16'h0000, 8'hF0);
        do_write(16'h0555, 8'h90);
        check("R4 F0 in unlock2", 32'(asel_active), 32'd0);
        enter(2'd2);
        check("R2 re-entry bank2", 32'(asel_active), 32'd1);
    endtask

    task automatic t_bank2();
        logic [15:0] d;
        do_read(16'h8000, 16'h1111, d);
        check("R2 bank2 mfr", 32'(d), 32'(MFR));
        do_read(16'h4000, 16'h2222, d);
        check("R8 old bank now array", 32'(d), 32'h2222);
        do_read(16'hB002, 16'h0000, d);
        check("R7 blk11", 32'(d), 32'd0);
        do_read(16'hA002, 16'h0000, d);
        check("R7 blk10", 32'(d), 32'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_normal_read();
        t_entry_and_ids();
        t_protect();
        t_other_bank_and_offsets();
        t_ignored_writes();
        t_exit();
        t_broken();
        t_partial_reset();
        t_bank2();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule